// File: doc/BRIEF.md
# Parity-Grouped Self-Checking Adder

This block is a 4-bit adder with carry-in whose five result bits (four sum bits and the carry-out) are split into two parity groups. For each group a separate predictor derives, straight from the operands, the parity that the group's result bits should have. A checker per group folds the group's result bits and its predicted bit through an XOR reduction and raises that group's error bit whenever the two disagree. A combined error flag ORs the group errors.

The logic is arranged so that no gate drives two result bits of the same group. Each result bit has its own private carry chain. The only gate shared between result bits is the carry into bit 1, and it feeds exactly one bit from each group. Any single internal fault therefore flips at most one bit per group, and parity catches it. A fault in the shared carry is reported in both groups.

A fault-injection port selects one numbered internal net and forces it to a chosen value. Site number 0 means no injection. The block is purely combinational.

Top module: `pgrp_adder`

## Requirements
- R1: With the fault-select input at 0, {cout_o, sum_o} equals a_i + b_i + cin_i for every operand combination.
- R2: With the fault-select input at 0, grp_err_o and err_o are both 0 for every operand combination.
- R3: Group 0 holds sum bits 0 and 2 and the carry-out. Group 1 holds sum bits 1 and 3. A fault on the output net of a result bit flags only that bit's group (grp_err_o bit 0 for group 0, bit 1 for group 1). The output-net sites are 2 (sum0), 24 (sum1), 46 (sum2), 68 (sum3) and 88 (carry-out).
- R4: Under any single stuck-at fault on any site 1 to 98, for any operands, a wrong {cout_o, sum_o} coincides with err_o = 1.
- R5: Under any single stuck-at fault, at most one result bit within each group differs from the fault-free value.
- R6: Site 94 is the shared carry into bit 1, which feeds sum1 and sum2. Forcing it to 0 with a=3, b=0, cin=1 gives sum_o = 4'b0010 and grp_err_o = 2'b11.
- R7: Sites 95 and 96 are the predicted parity bits of groups 0 and 1. Inverting one of them leaves the result bits correct and sets only that group's error bit.
- R8: Sites 97 and 98 are the check outputs of groups 0 and 1. Forcing one to 1 sets that group's error bit, and err_o = 1 whenever any group error bit is 1.
- R9: A fault-select value of 0, or any value above 98, has no effect on any output, whatever flt_val_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| cin_i | input | 1 | Carry-in |
| flt_sel_i | input | 7 | Fault site number; 0 disables injection |
| flt_val_i | input | 1 | Value forced onto the selected site |
| sum_o | output | 4 | Sum bits |
| cout_o | output | 1 | Carry-out |
| grp_err_o | output | 2 | Per-group parity mismatch |
| err_o | output | 1 | OR of all group errors |

## Verification
The embedded checks assume that at most one internal net is faulty at a time. The single site-select input guarantees this, so the checks can demand correct sums and a silent checker whenever the selector is 0. They also require that any corrupted result be flagged and that no group see more than one flipped bit. The stimulus stays within this single-fault model. For every site and both stuck values it applies all 512 operand and carry combinations. Directed cases then aim at the shared carry, the predictors, the check nodes and the unused selector codes.

// File: rtl/pgrp_pkg.sv
package pgrp_pkg;
  localparam int unsigned W          = 4;
  localparam int unsigned NOUT       = W + 1;
  localparam int unsigned NG         = 2;
  localparam int unsigned CONE_SITES = 4 * W + 2;
  localparam int unsigned SHR_BASE   = 1 + NOUT * CONE_SITES;
  localparam int unsigned PRED_BASE  = SHR_BASE + 4;
  localparam int unsigned CHK_BASE   = PRED_BASE + NG;
  localparam int unsigned NSITE      = CHK_BASE + NG - 1;
  localparam int unsigned FW         = $clog2(NSITE + 1);

  // group g membership mask at [g*NOUT +: NOUT]; bit k = result bit k, bit W = carry-out
  localparam logic [NG*NOUT-1:0] DEF_GRP_MAP = {5'b01010, 5'b10101};

  function automatic logic flt(input logic v, input int unsigned site,
                               input logic [FW-1:0] sel, input logic fv);
    return (sel == FW'(site)) ? fv : v;
  endfunction

  // carry into bit 1 may be shared only if bits 1 and 2 sit in different groups
  function automatic bit share_ok(input logic [NG*NOUT-1:0] map);
    for (int g = 0; g < NG; g++)
      if (map[g*NOUT+1] && map[g*NOUT+2]) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/pgrp_cone.sv
// One result bit with a private ripple chain from stage S0.
module pgrp_cone
  import pgrp_pkg::*;
#(
  parameter int unsigned K     = 0,
  parameter bit          IS_CO = 1'b0,
  parameter int unsigned S0    = 0,
  parameter int unsigned BASE  = 1,
  localparam int unsigned NB   = K - S0 + 1
) (
  input  logic [NB-1:0] a_i,
  input  logic [NB-1:0] b_i,
  input  logic          c_i,
  input  logic [FW-1:0] flt_sel_i,
  input  logic          flt_val_i,
  output logic          y_o
);
  localparam int unsigned NST = IS_CO ? K + 1 : K;

  logic [W-1:0] px, gx;
  assign px = (W'(a_i) ^ W'(b_i)) << S0;
  assign gx = (W'(a_i) & W'(b_i)) << S0;

  always_comb begin
    logic c, p, g, t;
    c = c_i;
    p = 1'b0;
    g = 1'b0;
    t = 1'b0;
    for (int j = 0; j < W; j++) begin
      if (j >= int'(S0) && j < int'(NST)) begin
        p = flt(px[j], BASE + 4*j,     flt_sel_i, flt_val_i);
        g = flt(gx[j], BASE + 4*j + 1, flt_sel_i, flt_val_i);
        t = flt(p & c, BASE + 4*j + 2, flt_sel_i, flt_val_i);
        c = flt(g | t, BASE + 4*j + 3, flt_sel_i, flt_val_i);
      end
    end
    if (IS_CO) begin
      y_o = c;
    end else begin
      p   = flt(px[K], BASE + 4*K, flt_sel_i, flt_val_i);
      y_o = flt(p ^ c, BASE + 4*K + 1, flt_sel_i, flt_val_i);
    end
  end
endmodule

// File: rtl/pgrp_pred.sv
// Predicted parity of one group, derived from the operands alone.
module pgrp_pred
  import pgrp_pkg::*;
#(
  parameter logic [NOUT-1:0] MASK = '1,
  parameter int unsigned     SITE = PRED_BASE
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          cin_i,
  input  logic [FW-1:0] flt_sel_i,
  input  logic          flt_val_i,
  output logic          par_o
);
  logic [NOUT-1:0] full;
  assign full  = NOUT'(a_i) + NOUT'(b_i) + NOUT'(cin_i);
  assign par_o = flt(^(full & MASK), SITE, flt_sel_i, flt_val_i);
endmodule

// File: rtl/pgrp_chk.sv
// XOR reduction of a group's result bits against its predicted parity.
module pgrp_chk
  import pgrp_pkg::*;
#(
  parameter logic [NOUT-1:0] MASK = '1,
  parameter int unsigned     SITE = CHK_BASE
) (
  input  logic [NOUT-1:0] y_i,
  input  logic            par_i,
  input  logic [FW-1:0]   flt_sel_i,
  input  logic            flt_val_i,
  output logic            err_o
);
  assign err_o = flt(^(y_i & MASK) ^ par_i, SITE, flt_sel_i, flt_val_i);

  always_comb begin
    if (flt_sel_i == '0) begin
      // R2
      no_false_alarm_chk: assert (!err_o);
    end
  end
endmodule

// File: rtl/pgrp_adder.sv
module pgrp_adder
  import pgrp_pkg::*;
#(
  parameter logic [NG*NOUT-1:0] GRP_MAP = DEF_GRP_MAP
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          cin_i,
  input  logic [FW-1:0] flt_sel_i,
  input  logic          flt_val_i,
  output logic [W-1:0]  sum_o,
  output logic          cout_o,
  output logic [NG-1:0] grp_err_o,
  output logic          err_o
);
  localparam bit SHARE_C1 = share_ok(GRP_MAP);

  logic [NOUT-1:0] y;
  logic [NG-1:0]   par;
  logic            c1_shr;

  if (SHARE_C1) begin : g_shr
    logic p0, g0, t0;
    always_comb begin
      p0     = flt(a_i[0] ^ b_i[0], SHR_BASE,     flt_sel_i, flt_val_i);
      g0     = flt(a_i[0] & b_i[0], SHR_BASE + 1, flt_sel_i, flt_val_i);
      t0     = flt(p0 & cin_i,      SHR_BASE + 2, flt_sel_i, flt_val_i);
      c1_shr = flt(g0 | t0,         SHR_BASE + 3, flt_sel_i, flt_val_i);
    end
  end else begin : g_noshr
    assign c1_shr = cin_i;
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_cone
    localparam int unsigned KK  = (k == W) ? W - 1 : k;
    localparam bit          ISC = (k == W);
    localparam int unsigned S0  = (SHARE_C1 && (k == 1 || k == 2)) ? 1 : 0;
    pgrp_cone #(
      .K(KK), .IS_CO(ISC), .S0(S0), .BASE(1 + k * CONE_SITES)
    ) u_cone (
      .a_i(a_i[KK:S0]),
      .b_i(b_i[KK:S0]),
      .c_i((S0 == 1) ? c1_shr : cin_i),
      .flt_sel_i(flt_sel_i),
      .flt_val_i(flt_val_i),
      .y_o(y[k])
    );
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    pgrp_pred #(
      .MASK(GRP_MAP[g*NOUT +: NOUT]), .SITE(PRED_BASE + g)
    ) u_pred (
      .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
      .flt_sel_i(flt_sel_i), .flt_val_i(flt_val_i),
      .par_o(par[g])
    );
    pgrp_chk #(
      .MASK(GRP_MAP[g*NOUT +: NOUT]), .SITE(CHK_BASE + g)
    ) u_chk (
      .y_i(y), .par_i(par[g]),
      .flt_sel_i(flt_sel_i), .flt_val_i(flt_val_i),
      .err_o(grp_err_o[g])
    );
  end

  assign sum_o  = y[W-1:0];
  assign cout_o = y[W];
  assign err_o  = |grp_err_o;

  logic [NOUT-1:0] exp_w;
  assign exp_w = NOUT'(a_i) + NOUT'(b_i) + NOUT'(cin_i);

  always_comb begin
    if (flt_sel_i == '0) begin
      // R1
      sum_exact_chk: assert ({cout_o, sum_o} == exp_w);
    end
    // R4
    wrong_flagged_chk: assert (({cout_o, sum_o} == exp_w) || err_o);
    for (int g = 0; g < NG; g++) begin
      // R5
      one_flip_chk: assert ($countones(({cout_o, sum_o} ^ exp_w) & GRP_MAP[g*NOUT +: NOUT]) <= 1);
    end
  end
endmodule

// File: tb/pgrp_adder_test.sv
module pgrp_adder_test;
  logic       clk = 1'b0;
  logic [3:0] a_r = '0, b_r = '0;
  logic       c_r = 1'b0;
  logic [6:0] sel_r = '0;
  logic       fv_r = 1'b0;
  logic [3:0] sum_w;
  logic       cout_w, err_w;
  logic [1:0] gerr_w;
  int n_run = 0, n_fail = 0;

  localparam logic [4:0] G0 = 5'b10101;
  localparam logic [4:0] G1 = 5'b01010;
  localparam int NS = 98;
  // {a, b, cin, expected {cout,sum}}
  localparam logic [13:0] VEC [8] = '{
    {4'h0, 4'h0, 1'b0, 5'd0},  {4'hF, 4'hF, 1'b1, 5'd31},
    {4'hF, 4'h1, 1'b0, 5'd16}, {4'h5, 4'hA, 1'b0, 5'd15},
    {4'h9, 4'h7, 1'b1, 5'd17}, {4'h8, 4'h8, 1'b0, 5'd16},
    {4'h3, 4'h0, 1'b1, 5'd4},  {4'h6, 4'h3, 1'b1, 5'd10}};

  always #2 clk = ~clk;

  pgrp_adder uut (
    .a_i(a_r), .b_i(b_r), .cin_i(c_r), .flt_sel_i(sel_r), .flt_val_i(fv_r),
    .sum_o(sum_w), .cout_o(cout_w), .grp_err_o(gerr_w), .err_o(err_w));

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic c,
                       input logic [6:0] s, input logic v);
    @(negedge clk);
    a_r = a; b_r = b; c_r = c; sel_r = s; fv_r = v;
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_sum(input logic [3:0] a, input logic [3:0] b, input logic c);
    return 5'(a) + 5'(b) + 5'(c);
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    // idle state: zero operands, no injection (R1, R2)
    apply(4'h0, 4'h0, 1'b0, 7'd0, 1'b0);
    chk({cout_w, sum_w} == 5'd0, "R1 idle sum", int'({cout_w, sum_w}), 0);
    chk(gerr_w == 2'b00 && !err_w, "R2 idle error", int'({gerr_w, err_w}), 0);

    // table walk (R1, R2)
    foreach (VEC[i]) begin
      apply(VEC[i][13:10], VEC[i][9:6], VEC[i][5], 7'd0, 1'b0);
      chk({cout_w, sum_w} == VEC[i][4:0], "R1 table sum", int'({cout_w, sum_w}), int'(VEC[i][4:0]));
      chk(gerr_w == 2'b00 && !err_w, "R2 table error", int'({gerr_w, err_w}), 0);
    end

    // output-net sites land in their own group only (R3)
    for (int k = 0; k < 5; k++) begin
      int site;
      logic [4:0] e;
      site = 1 + 18 * k + ((k == 4) ? 15 : 4 * k + 1);
      e = ref_sum(4'h5, 4'h6, 1'b0);
      apply(4'h5, 4'h6, 1'b0, 7'(site), ~e[k]);
      chk(({cout_w, sum_w} ^ e) == 5'(1 << k), "R3 single flip", int'({cout_w, sum_w}), int'(e ^ 5'(1 << k)));
      chk(gerr_w == (G1[k] ? 2'b10 : 2'b01), "R3 group select", int'(gerr_w), G1[k] ? 2 : 1);
    end

    // shared carry into bit 1 (R6)
    apply(4'h3, 4'h0, 1'b1, 7'd94, 1'b0);
    chk(sum_w == 4'b0010 && !cout_w, "R6 shared fault sum", int'({cout_w, sum_w}), 2);
    chk(gerr_w == 2'b11, "R6 both groups", int'(gerr_w), 3);

    // predictor sites (R7): 5+6 = 01011, group0 parity 1, group1 parity 0
    apply(4'h5, 4'h6, 1'b0, 7'd95, 1'b0);
    chk({cout_w, sum_w} == 5'd11 && gerr_w == 2'b01, "R7 pred0", int'({cout_w, sum_w, gerr_w}), 45);
    apply(4'h5, 4'h6, 1'b0, 7'd96, 1'b1);
    chk({cout_w, sum_w} == 5'd11 && gerr_w == 2'b10, "R7 pred1", int'({cout_w, sum_w, gerr_w}), 46);

    // check nodes and combined flag (R8)
    apply(4'h0, 4'h0, 1'b0, 7'd97, 1'b1);
    chk(gerr_w == 2'b01 && err_w, "R8 chk0", int'({gerr_w, err_w}), 3);
    apply(4'h0, 4'h0, 1'b0, 7'd98, 1'b1);
    chk(gerr_w == 2'b10 && err_w, "R8 chk1", int'({gerr_w, err_w}), 5);

    // disabled and out-of-range selectors (R9)
    apply(4'hF, 4'hF, 1'b1, 7'd0, 1'b1);
    chk({cout_w, sum_w} == 5'd31 && !err_w && gerr_w == 2'b00, "R9 sel zero", int'({cout_w, sum_w, err_w}), 62);
    begin
      int bad = 0;
      for (int s = 99; s < 128; s++) begin
        for (int v = 0; v < 2; v++) begin
          apply(4'h9, 4'h7, 1'b1, 7'(s), 1'(v));
          if ({cout_w, sum_w} != 5'd17 || err_w || gerr_w != 2'b00) bad++;
          apply(4'h0, 4'h0, 1'b0, 7'(s), 1'(v));
          if ({cout_w, sum_w} != 5'd0 || err_w || gerr_w != 2'b00) bad++;
        end
      end
      chk(bad == 0, "R9 unused sites", bad, 0);
    end

    // exhaustive single stuck-at sweep (R4, R5)
    for (int s = 1; s <= NS; s++) begin
      for (int v = 0; v < 2; v++) begin
        int miss = 0, multi = 0;
        for (int x = 0; x < 512; x++) begin
          logic [8:0] xv;
          logic [4:0] e, d;
          xv = 9'(x);
          e = ref_sum(xv[3:0], xv[7:4], xv[8]);
          apply(xv[3:0], xv[7:4], xv[8], 7'(s), 1'(v));
          d = {cout_w, sum_w} ^ e;
          if (d != 5'd0 && !err_w) miss++;
          if ($countones(d & G0) > 1 || $countones(d & G1) > 1) multi++;
        end
        chk(miss == 0, $sformatf("R4 site %0d val %0d undetected", s, v), miss, 0);
        chk(multi == 0, $sformatf("R5 site %0d val %0d multi-flip", s, v), multi, 0);
      end
    end

    summary();
    $finish;
  end
endmodule